// File: doc/BRIEF.md
# Flash Supply Idle Governor

This block decides when the flash subsystem has power. Accesses arrive as a level request. A separate one-cycle pulse marks other activity. A free-running cycle count acts as a clock, and the block stores the count of the most recent activity as a timestamp. A coarse check tick fires once per check period. On each tick, if the subsystem is on, nothing is being requested, and the time since the stored timestamp is greater than the idle limit, the block powers down. It first drops the supply enable. One cycle later it puts the pads into their inactive state.

If a request arrives while the subsystem is off, the request waits. The block turns on the pads and the supply and waits a settle interval. It then asks the command sequencer to reset each populated bank, one at a time and in ascending order. The grant is raised only when this sequence is complete. If any bank reports a failed reset, the block enters a fatal state that only reset clears. In that state no grant is ever issued. Every time interval is a parameter counted in clock cycles.

Top module: `flash_pwr_gov`

## Requirements
- R1: After reset, supply_en_o, pad_en_o, gnt_o, rst_req_o and fatal_o are all low.
- R2: When req_i is seen while the subsystem is off, supply_en_o and pad_en_o both go high at the next clock edge, and gnt_o stays low.
- R3: rst_req_o does not rise until at least SETTLE_CYC cycles after supply_en_o rose.
- R4: Resets go only to banks whose bit in bank_present_i is 1, in ascending index order. rst_bank_o carries the bank index. Each request holds rst_req_o and rst_bank_o steady until rst_ack_i is high for one cycle. Absent banks get no reset.
- R5: gnt_o stays low until every present bank has been reset. After that, gnt_o follows req_i while the subsystem is on.
- R6: With no activity, supply_en_o falls at a check tick. The tick is more than IDLE_CYC cycles and at most IDLE_CYC+CHECK_CYC cycles after the last timestamp refresh.
- R7: A high cycle on activity_i refreshes the timestamp, so periodic pulses spaced below IDLE_CYC keep the subsystem on.
- R8: The rise and the fall of gnt_o each refresh the timestamp. The subsystem never powers down while req_i is high.
- R9: On power-down, supply_en_o falls first and pad_en_o falls exactly one cycle later.
- R10: If rst_ack_i arrives with rst_fail_i high, fatal_o goes high and stays high until reset. While fatal_o is high, gnt_o stays low even if req_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| activity_i | input | 1 | One-cycle activity pulse; refreshes the timestamp |
| req_i | input | 1 | Access request, held high for the whole access |
| gnt_o | output | 1 | Access grant |
| supply_en_o | output | 1 | Flash supply enable |
| pad_en_o | output | 1 | Pads active (1) or inactive (0) |
| bank_present_i | input | NBANK | Populated-bank mask, bit i for bank i |
| rst_req_o | output | 1 | Bank reset request to the command sequencer |
| rst_bank_o | output | $clog2(NBANK) | Index of the bank to reset |
| rst_ack_i | input | 1 | Reset finished (one-cycle pulse) |
| rst_fail_i | input | 1 | Reset failed; sampled while rst_ack_i is high |
| fatal_o | output | 1 | Sticky fatal flag |

## Verification
Power-up is tried with three bank masks:
- A sparse mask (0, 1, 3) shows that absent banks are skipped and that the order is ascending.
- An empty mask shows that the grant still arrives after the settle interval.
- A mask whose second member fails shows the fatal lockout.

The idle timeout is measured from three kinds of last event: an activity pulse, the fall of the grant, and a long held request. These tell apart refresh by pulse, refresh by grant edge, and the rule that a held request blocks power-down. Each measured delay must fall inside the window set by the idle limit and the check period.

// File: rtl/flash_pwr_gov.sv
module flash_pwr_gov #(
  parameter int NBANK      = 4,
  parameter int SETTLE_CYC = 2_500_000,
  parameter int IDLE_CYC   = 10_000_000,
  parameter int CHECK_CYC  = 5_000_000,
  parameter int TS_W       = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               activity_i,
  input  logic               req_i,
  output logic               gnt_o,
  output logic               supply_en_o,
  output logic               pad_en_o,
  input  logic [NBANK-1:0]   bank_present_i,
  output logic               rst_req_o,
  output logic [$clog2(NBANK)-1:0] rst_bank_o,
  input  logic               rst_ack_i,
  input  logic               rst_fail_i,
  output logic               fatal_o
);
  localparam int BW  = $clog2(NBANK);
  localparam int SW  = $clog2(SETTLE_CYC + 1);
  localparam int CKW = $clog2(CHECK_CYC + 1);

  typedef enum logic [2:0] {S_OFF, S_SETTLE, S_SCAN, S_RST, S_ON, S_PDN, S_FAULT} st_t;

  st_t            st;
  logic [TS_W-1:0] now, last;
  logic [CKW-1:0] ck_cnt;
  logic [SW-1:0]  sc;
  logic [BW:0]    bidx;
  logic           gnt_d;

  wire [BW-1:0]   bsel      = bidx[BW-1:0];
  wire            tick      = (ck_cnt == CKW'(CHECK_CYC - 1));
  wire [TS_W-1:0] elapsed   = now - last;
  wire            idle      = elapsed > TS_W'(IDLE_CYC);
  wire            bank_done = (bidx == (BW+1)'(NBANK));

  assign gnt_o      = (st == S_ON) && req_i;
  assign rst_req_o  = (st == S_RST);
  assign rst_bank_o = bsel;
  assign fatal_o    = (st == S_FAULT);

  wire touch = activity_i || (gnt_o != gnt_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OFF;
      now         <= '0;
      last        <= '0;
      ck_cnt      <= '0;
      sc          <= '0;
      bidx        <= '0;
      gnt_d       <= 1'b0;
      supply_en_o <= 1'b0;
      pad_en_o    <= 1'b0;
    end else begin
      now    <= now + 1'b1;
      ck_cnt <= tick ? '0 : ck_cnt + 1'b1;
      gnt_d  <= gnt_o;
      if (touch) last <= now;
      case (st)
        S_OFF: if (req_i) begin
          supply_en_o <= 1'b1;
          pad_en_o    <= 1'b1;
          last        <= now;
          sc          <= '0;
          st          <= S_SETTLE;
        end
        S_SETTLE: if (sc == SW'(SETTLE_CYC - 1)) begin
          last <= now;
          bidx <= '0;
          st   <= S_SCAN;
        end else sc <= sc + 1'b1;
        S_SCAN: if (bank_done) begin
          last <= now;
          st   <= S_ON;
        end else if (bank_present_i[bsel]) st <= S_RST;
        else bidx <= bidx + 1'b1;
        S_RST: if (rst_ack_i) begin
          if (rst_fail_i) st <= S_FAULT;
          else begin
            bidx <= bidx + 1'b1;
            st   <= S_SCAN;
          end
        end
        S_ON: if (tick && idle && !req_i && !touch) begin
          supply_en_o <= 1'b0;
          st          <= S_PDN;
        end
        S_PDN: begin
          pad_en_o <= 1'b0;
          st       <= S_OFF;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_pwr_gov_chk.sv
module flash_pwr_gov_chk #(
  parameter int NBANK      = 4,
  parameter int SETTLE_CYC = 2_500_000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     gnt_o,
  input logic                     supply_en_o,
  input logic                     pad_en_o,
  input logic [NBANK-1:0]         bank_present_i,
  input logic                     rst_req_o,
  input logic [$clog2(NBANK)-1:0] rst_bank_o,
  input logic                     rst_ack_i,
  input logic                     fatal_o
);
  logic [31:0] on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_cnt <= '0;
    else if (!supply_en_o) on_cnt <= '0;
    else if (on_cnt != 32'hFFFF_FFFF) on_cnt <= on_cnt + 1'b1;
  end

  a_r2_pads_with_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en_o) |-> pad_en_o);
  a_r3_settle_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> on_cnt >= 32'(SETTLE_CYC));
  a_r4_reset_only_present: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> bank_present_i[rst_bank_o]);
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !rst_ack_i) |=> (rst_req_o && $stable(rst_bank_o)));
  a_r5_grant_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> (supply_en_o && pad_en_o && !rst_req_o));
  a_r9_supply_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_o) |-> pad_en_o);
  a_r9_pads_after_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_en_o) |-> !supply_en_o);
  a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);
  a_r10_no_grant_when_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> !gnt_o);
endmodule

bind flash_pwr_gov flash_pwr_gov_chk #(.NBANK(NBANK), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_o(gnt_o), .supply_en_o(supply_en_o),
  .pad_en_o(pad_en_o), .bank_present_i(bank_present_i), .rst_req_o(rst_req_o),
  .rst_bank_o(rst_bank_o), .rst_ack_i(rst_ack_i), .fatal_o(fatal_o));

// File: tb/test_flash_pwr_gov.sv
module test_flash_pwr_gov;
  localparam int NBANK = 4, SETTLE = 20, IDLE = 50, CHECK = 16;

  logic clk = 0, rst_n = 0, activity = 0, req = 0, ack = 0, fail = 0;
  logic [NBANK-1:0] present = '0;
  logic gnt, supply, pad, rreq, fatal;
  logic [1:0] rbank;

  int n_chk = 0, n_bad = 0, cyc = 0, fail_bank = 99, wt = 0;
  int exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  flash_pwr_gov #(.NBANK(NBANK), .SETTLE_CYC(SETTLE), .IDLE_CYC(IDLE),
                  .CHECK_CYC(CHECK), .TS_W(32)) i_flash_pwr_gov (
    .clk(clk), .rst_n(rst_n), .activity_i(activity), .req_i(req), .gnt_o(gnt),
    .supply_en_o(supply), .pad_en_o(pad), .bank_present_i(present),
    .rst_req_o(rreq), .rst_bank_o(rbank), .rst_ack_i(ack), .rst_fail_i(fail),
    .fatal_o(fatal));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse();
    activity = 1;
    step();
    activity = 0;
  endtask

  // scoreboard monitor: acts as the sequencer, pops the expected bank order (R4)
  always @(negedge clk) begin
    ack = 0;
    fail = 0;
    if (rreq) begin
      if (wt == 2) begin
        ack = 1;
        fail = (int'(rbank) == fail_bank);
        if (exp_q.size() == 0) chk(0, "R4 unexpected reset", int'(rbank), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(rbank) == e, "R4 bank order", int'(rbank), e);
        end
        wt = 0;
      end else wt++;
    end else wt = 0;
  end

  task automatic idle_measure(input string r, output int d);
    d = 0;
    while (supply && d < 300) begin
      step();
      d++;
    end
  endtask

  initial begin
    int n, d;
    bit saw;
    repeat (3) step();
    rst_n = 1;
    step();
    chk(!supply && !pad && !gnt && !rreq && !fatal, "R1 reset outputs",
        {supply, pad, gnt, rreq, fatal}, 0);

    // sparse mask: banks 0,1,3
    present = 4'b1011;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(3);
    req = 1;
    step();
    chk(supply && pad, "R2 supply and pads on", {supply, pad}, 3);
    chk(!gnt, "R2 grant held", gnt, 0);
    n = 0;
    while (!rreq && n < 200) begin step(); n++; end
    chk(n >= SETTLE, "R3 settle before reset", n, SETTLE);
    saw = 0;
    n = 0;
    while (!gnt && n < 200) begin step(); n++; end
    chk(gnt, "R5 grant after sequence", gnt, 1);
    chk(exp_q.size() == 0, "R5 all resets done before grant", exp_q.size(), 0);
    req = 0;
    step();
    chk(!gnt, "R5 grant follows request", gnt, 0);

    // keep alive with pulses
    for (int i = 0; i < 8; i++) begin
      pulse();
      repeat (30) step();
    end
    chk(supply, "R7 pulses keep power", supply, 1);

    // timeout measured from an activity pulse
    pulse();
    idle_measure("R6", d);
    chk(d > IDLE && d <= IDLE + CHECK, "R6 idle window", d, IDLE + 1);
    chk(!supply && pad, "R9 supply falls first", {supply, pad}, 1);
    step();
    chk(!pad, "R9 pads one cycle later", pad, 0);

    // empty mask: no resets, grant after settle
    present = 4'b0000;
    req = 1;
    n = 0;
    while (!gnt && n < 200) begin step(); n++; end
    chk(gnt && n >= SETTLE, "R4 empty mask grant", n, SETTLE);
    repeat (3 * IDLE) step();
    chk(supply && gnt, "R8 held request blocks power-down", {supply, gnt}, 3);
    req = 0;
    step();
    idle_measure("R8", d);
    chk(d > IDLE && d <= IDLE + CHECK, "R8 grant fall refreshes", d, IDLE + 1);
    step();
    chk(!supply && !pad, "R9 fully off", {supply, pad}, 0);

    // failing reset on bank 2
    present = 4'b0110;
    fail_bank = 2;
    exp_q.push_back(1); exp_q.push_back(2);
    req = 1;
    n = 0;
    while (!fatal && n < 200) begin step(); n++; end
    chk(fatal, "R10 fatal raised", fatal, 1);
    saw = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (gnt) saw = 1;
    end
    chk(!saw, "R10 no grant while fatal", saw, 0);
    chk(fatal, "R10 fatal sticky", fatal, 1);
    req = 0;
    step();
    chk(exp_q.size() == 0, "R4 all expected resets seen", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    wait (cyc == 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule